// File: doc/BRIEF.md
# Edge-Qualified Up/Down Event Counter with Done Status

This block is a controller-style event counter. It has two rung inputs, one that counts up and one that counts down. The accumulator moves by one count only when a rung input goes from low to high. Holding a rung high does not add further counts. Both rungs act on one signed accumulator. A done flag compares that accumulator with a signed preset input on every cycle, using a greater-or-equal rule.

The accumulator is retentive. It keeps its value when the rungs go low, and only the clear command or the block's reset brings it back to zero. Counting past either end of the signed range wraps the value round. The wrap also raises a sticky flag that records the event until the next clear. The block is meant to sit behind logic that already supplies clean, synchronised rung levels. It needs no configuration beyond the preset value.

Top module: `ladder_counter`

## Requirements
- R1: A low-to-high transition of `up_rung` sampled at a rising clock edge adds one to `acc` at that edge. Holding `up_rung` high for further cycles adds nothing more.
- R2: A low-to-high transition of `dn_rung` sampled at a rising clock edge subtracts one from `acc` at that edge.
- R3: If both rungs rise at the same clock edge, `acc` is unchanged. A rising rung whose partner is only held high still counts.
- R4: While `clr_cmd` is low, `done` is 1 exactly when `acc` is greater than or equal to `preset`. Both are compared as two's-complement signed values. A change of `preset` shows on `done` in the same cycle.
- R5: `acc` is retentive. A rung going from high to low, or staying idle, leaves `acc` unchanged.
- R6: When `clr_cmd` is high at a clock edge, that edge sets `acc` to 0 and clears `ovf` and `unf`, and any rung transition at that edge is ignored. While `clr_cmd` is high, `up_en`, `dn_en` and `done` read 0.
- R7: While `clr_cmd` is low, `up_en` equals the present level of `up_rung` and `dn_en` equals the present level of `dn_rung`.
- R8: Counting up from +32767 gives -32768 and sets `ovf`. `ovf` then stays at 1 until a clear or reset.
- R9: Counting down from -32768 gives +32767 and sets `unf`. `unf` then stays at 1 until a clear or reset.
- R10: The clear command and the reset both make the block forget the previous rung levels. A rung that is held high while `clr_cmd` falls therefore counts once, at the first edge after the clear is released.
- R11: While `rst` is high, each clock edge sets `acc` to 0 and clears `ovf` and `unf`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high block reset |
| up_rung | input | 1 | Count-up rung level |
| dn_rung | input | 1 | Count-down rung level |
| clr_cmd | input | 1 | Synchronous clear command, active high |
| preset | input | 16 | Signed comparison threshold |
| acc | output | 16 | Signed accumulated count |
| up_en | output | 1 | Count-up rung is active |
| dn_en | output | 1 | Count-down rung is active |
| done | output | 1 | Accumulator is at or above the preset |
| ovf | output | 1 | Sticky flag: the count wrapped at the positive end |
| unf | output | 1 | Sticky flag: the count wrapped at the negative end |

## Verification
Four rung patterns are used, and each one isolates a different fault:
- A rung pulsed low and high, against the same rung held high, shows whether the design counts transitions or levels.
- Both rungs rising together, against one rising while the other stays high, shows whether the cancellation case is detected per edge.
- A rung held high across the release of the clear command shows whether the stored rung history is cleared.
- A count up through +32767 and back down through -32768 exercises both wrap directions and shows that the two sticky flags are independent.

The preset is moved above, onto and below the count, and also to negative values. This checks that `done` uses a signed greater-or-equal comparison.

// File: rtl/lctr_pkg.sv
package lctr_pkg;

    localparam int unsigned LCTR_W = 16;

    typedef enum logic [1:0] {
        STEP_HOLD = 2'd0,
        STEP_INC  = 2'd1,
        STEP_DEC  = 2'd2
    } step_e;

    typedef struct packed {
        logic ovf;
        logic unf;
    } wrap_t;

    // Opposing edges in one cycle cancel each other.
    function automatic step_e pick_step(input logic up_rise, input logic dn_rise);
        if (up_rise && !dn_rise) return STEP_INC;
        if (dn_rise && !up_rise) return STEP_DEC;
        return STEP_HOLD;
    endfunction

endpackage

// File: rtl/lctr_edge.sv
module lctr_edge #(
    parameter int unsigned LANES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic [LANES-1:0] rung,
    output logic [LANES-1:0] rise
);

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic prev_q;

        always_ff @(posedge clk) begin
            if (rst || clr) prev_q <= 1'b0;
            else            prev_q <= rung[i];
        end

        assign rise[i] = rung[i] & ~prev_q;
    end

endmodule

// File: rtl/lctr_accum.sv
module lctr_accum
    import lctr_pkg::*;
#(
    parameter int unsigned CNT_W = LCTR_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  step_e            step,
    output logic [CNT_W-1:0] acc,
    output wrap_t            wrap
);

    localparam logic [CNT_W-1:0] ACC_MAX = {1'b0, {(CNT_W-1){1'b1}}};
    localparam logic [CNT_W-1:0] ACC_MIN = {1'b1, {(CNT_W-1){1'b0}}};
    localparam logic [CNT_W-1:0] ONE     = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [CNT_W-1:0] acc_q;
    wrap_t            wrap_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            acc_q  <= '0;
            wrap_q <= '0;
        end else begin
            case (step)
                STEP_INC: begin
                    acc_q <= acc_q + ONE;
                    if (acc_q == ACC_MAX) wrap_q.ovf <= 1'b1;
                end
                STEP_DEC: begin
                    acc_q <= acc_q - ONE;
                    if (acc_q == ACC_MIN) wrap_q.unf <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    assign acc  = acc_q;
    assign wrap = wrap_q;

endmodule

// File: rtl/lctr_status.sv
module lctr_status #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clr,
    input  logic             up_rung,
    input  logic             dn_rung,
    input  logic [CNT_W-1:0] acc,
    input  logic [CNT_W-1:0] preset,
    output logic             up_en,
    output logic             dn_en,
    output logic             done
);

    logic reached;

    always_comb begin
        reached = $signed(acc) >= $signed(preset);
        up_en   = up_rung & ~clr;
        dn_en   = dn_rung & ~clr;
        done    = reached & ~clr;
    end

endmodule

// File: rtl/ladder_counter.sv
module ladder_counter
    import lctr_pkg::*;
#(
    parameter int unsigned CNT_W = LCTR_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             up_rung,
    input  logic             dn_rung,
    input  logic             clr_cmd,
    input  logic [CNT_W-1:0] preset,
    output logic [CNT_W-1:0] acc,
    output logic             up_en,
    output logic             dn_en,
    output logic             done,
    output logic             ovf,
    output logic             unf
);

    localparam int unsigned LANE_UP = 0;
    localparam int unsigned LANE_DN = 1;

    logic [1:0] rung_lv;
    logic [1:0] rung_rise;
    step_e      step;
    wrap_t      wrap;

    assign rung_lv[LANE_UP] = up_rung;
    assign rung_lv[LANE_DN] = dn_rung;

    lctr_edge #(.LANES(2)) u_edge (
        .clk  (clk),
        .rst  (rst),
        .clr  (clr_cmd),
        .rung (rung_lv),
        .rise (rung_rise)
    );

    assign step = pick_step(rung_rise[LANE_UP], rung_rise[LANE_DN]);

    lctr_accum #(.CNT_W(CNT_W)) u_accum (
        .clk  (clk),
        .rst  (rst),
        .clr  (clr_cmd),
        .step (step),
        .acc  (acc),
        .wrap (wrap)
    );

    lctr_status #(.CNT_W(CNT_W)) u_status (
        .clr     (clr_cmd),
        .up_rung (up_rung),
        .dn_rung (dn_rung),
        .acc     (acc),
        .preset  (preset),
        .up_en   (up_en),
        .dn_en   (dn_en),
        .done    (done)
    );

    assign ovf = wrap.ovf;
    assign unf = wrap.unf;

endmodule

// File: rtl/lctr_checker.sv
module lctr_checker #(
    parameter int unsigned CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             up_rung,
    input logic             dn_rung,
    input logic             clr_cmd,
    input logic [CNT_W-1:0] preset,
    input logic [CNT_W-1:0] acc,
    input logic             up_en,
    input logic             dn_en,
    input logic             done,
    input logic             ovf,
    input logic             unf
);

    assert_clear_R6: assert property (@(posedge clk) disable iff (rst)
        clr_cmd |=> (acc == '0) && !ovf && !unf);

    assert_quiet_R6: assert property (@(posedge clk) disable iff (rst)
        clr_cmd |-> !up_en && !dn_en && !done);

    assert_reset_R11: assert property (@(posedge clk)
        rst |=> (acc == '0) && !ovf && !unf);

    assert_levels_R7: assert property (@(posedge clk) disable iff (rst)
        !clr_cmd |-> (up_en == up_rung) && (dn_en == dn_rung));

    assert_done_R4: assert property (@(posedge clk) disable iff (rst)
        !clr_cmd |-> done == ($signed(acc) >= $signed(preset)));

    assert_retain_R5: assert property (@(posedge clk) disable iff (rst)
        (!clr_cmd && !$past(clr_cmd) && !$past(rst)
         && !(up_rung && !$past(up_rung)) && !(dn_rung && !$past(dn_rung)))
        |=> $stable(acc));

    assert_cancel_R3: assert property (@(posedge clk) disable iff (rst)
        (!clr_cmd && !$past(clr_cmd) && !$past(rst)
         && up_rung && !$past(up_rung) && dn_rung && !$past(dn_rung))
        |=> $stable(acc));

    assert_ovf_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        (ovf && !clr_cmd) |=> ovf);

    assert_unf_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        (unf && !clr_cmd) |=> unf);

endmodule

bind ladder_counter lctr_checker #(.CNT_W(CNT_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .up_rung (up_rung),
    .dn_rung (dn_rung),
    .clr_cmd (clr_cmd),
    .preset  (preset),
    .acc     (acc),
    .up_en   (up_en),
    .dn_en   (dn_en),
    .done    (done),
    .ovf     (ovf),
    .unf     (unf)
);

// File: tb/ladder_counter_tb.sv
`timescale 1ns/1ps
module ladder_counter_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        up_rung = 1'b0;
    logic        dn_rung = 1'b0;
    logic        clr_cmd = 1'b0;
    logic [15:0] preset = '0;
    logic [15:0] acc;
    logic        up_en, dn_en, done, ovf, unf;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    // behavioural model state
    int m_acc = 0;
    bit m_up_prev = 0, m_dn_prev = 0, m_ovf = 0, m_unf = 0;

    always #10 clk = ~clk;

    ladder_counter u_dut (
        .clk(clk), .rst(rst), .up_rung(up_rung), .dn_rung(dn_rung),
        .clr_cmd(clr_cmd), .preset(preset), .acc(acc), .up_en(up_en),
        .dn_en(dn_en), .done(done), .ovf(ovf), .unf(unf)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic compare(input string tag);
        int a_act;
        int p_val;
        bit e_done;
        a_act  = int'($signed(acc));
        p_val  = int'($signed(preset));
        e_done = !clr_cmd && (m_acc >= p_val);
        chk(a_act == m_acc, tag, "acc", a_act, m_acc);
        chk(up_en == (up_rung && !clr_cmd), tag, "up_en", int'(up_en), int'(up_rung && !clr_cmd));
        chk(dn_en == (dn_rung && !clr_cmd), tag, "dn_en", int'(dn_en), int'(dn_rung && !clr_cmd));
        chk(done == e_done, tag, "done", int'(done), int'(e_done));
        chk(ovf == m_ovf, tag, "ovf", int'(ovf), int'(m_ovf));
        chk(unf == m_unf, tag, "unf", int'(unf), int'(m_unf));
    endtask

    task automatic model_edge();
        bit ru, rd;
        if (rst || clr_cmd) begin
            m_acc = 0; m_ovf = 0; m_unf = 0;
            m_up_prev = 0; m_dn_prev = 0;
        end else begin
            ru = up_rung && !m_up_prev;
            rd = dn_rung && !m_dn_prev;
            if (ru && !rd) begin
                if (m_acc == 32767) begin m_acc = -32768; m_ovf = 1; end
                else m_acc = m_acc + 1;
            end else if (rd && !ru) begin
                if (m_acc == -32768) begin m_acc = 32767; m_unf = 1; end
                else m_acc = m_acc - 1;
            end
            m_up_prev = up_rung;
            m_dn_prev = dn_rung;
        end
    endtask

    // One clock: drive at the falling edge, compare, then advance the model.
    task automatic cyc(input bit u, input bit d, input bit c, input int p,
                       input string tag);
        @(negedge clk);
        up_rung = u; dn_rung = d; clr_cmd = c; preset = 16'(p);
        #1;
        compare(tag);
        @(posedge clk);
        model_edge();
    endtask

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000) begin
            errors++;
            $display("FAIL watchdog expired after %0d cycles", cycles);
            summary();
            $finish;
        end
    end

    initial begin
        // R11: reset
        for (int i = 0; i < 3; i++) cyc(0, 0, 0, 0, "R11");
        @(negedge clk); rst = 1'b0; #1;
        chk(acc == 16'd0 && !ovf && !unf, "R11", "reset state acc", int'($signed(acc)), 0);

        // R1: pulsed transitions count; held level counts once
        cyc(1, 0, 0, 10, "R1"); cyc(0, 0, 0, 10, "R1");
        cyc(1, 0, 0, 10, "R1"); cyc(0, 0, 0, 10, "R1");
        for (int i = 0; i < 5; i++) cyc(1, 0, 0, 10, "R1");
        #2 chk(int'($signed(acc)) == 3, "R1", "held level count", int'($signed(acc)), 3);

        // R5: release and idle keep the value
        for (int i = 0; i < 4; i++) cyc(0, 0, 0, 10, "R5");
        #2 chk(int'($signed(acc)) == 3, "R5", "retained count", int'($signed(acc)), 3);

        // R2: count down
        cyc(0, 1, 0, 10, "R2"); cyc(0, 0, 0, 10, "R2");
        cyc(0, 1, 0, 10, "R2"); cyc(0, 0, 0, 10, "R2");
        #2 chk(int'($signed(acc)) == 1, "R2", "after two downs", int'($signed(acc)), 1);

        // R3: simultaneous rises cancel; rise while partner held counts
        cyc(1, 1, 0, 10, "R3"); cyc(1, 1, 0, 10, "R3");
        #2 chk(int'($signed(acc)) == 1, "R3", "both rise", int'($signed(acc)), 1);
        cyc(1, 0, 0, 10, "R3"); cyc(1, 1, 0, 10, "R3"); cyc(1, 1, 0, 10, "R3");
        #2 chk(int'($signed(acc)) == 0, "R3", "down with up held", int'($signed(acc)), 0);
        cyc(0, 0, 0, 10, "R3");

        // R4: preset sweep around the count, signed compare
        cyc(0, 1, 0, 0, "R4"); cyc(0, 0, 0, 0, "R4");     // acc -1
        cyc(0, 0, 0, -1, "R4"); cyc(0, 0, 0, 0, "R4");
        cyc(0, 0, 0, -2, "R4"); cyc(0, 0, 0, -32768, "R4");
        cyc(0, 0, 0, 32767, "R4");
        @(negedge clk); preset = 16'hFFFF; #1;
        chk(done == 1'b1, "R4", "done at equal negative preset", int'(done), 1);
        preset = 16'h0000; #1;
        chk(done == 1'b0, "R4", "done below preset", int'(done), 0);
        @(posedge clk); model_edge();

        // R7: enables follow levels
        cyc(1, 0, 0, 0, "R7"); cyc(1, 1, 0, 0, "R7"); cyc(0, 1, 0, 0, "R7"); cyc(0, 0, 0, 0, "R7");

        // R6: clear with a rising rung; outputs quiet during clear
        cyc(1, 0, 1, -5, "R6"); cyc(1, 1, 1, -5, "R6");
        // R10: rung held across clear release counts once
        cyc(1, 0, 0, -5, "R10"); cyc(1, 0, 0, -5, "R10"); cyc(1, 0, 0, -5, "R10");
        #2 chk(int'($signed(acc)) == 1, "R10", "count after clear release", int'($signed(acc)), 1);
        cyc(0, 0, 1, 0, "R6"); cyc(0, 0, 0, 0, "R6");

        // R8: count to the top and wrap
        for (int i = 0; i < 32768; i++) begin
            cyc(1, 0, 0, 100, "R8");
            cyc(0, 0, 0, 100, "R8");
        end
        #2 chk(int'($signed(acc)) == -32768 && ovf, "R8", "wrap to min with ovf",
               int'($signed(acc)), -32768);

        // R9: count down from the bottom and wrap
        cyc(0, 1, 0, 100, "R9"); cyc(0, 0, 0, 100, "R9"); cyc(0, 0, 0, 100, "R9");
        #2 chk(int'($signed(acc)) == 32767 && unf && ovf, "R9", "wrap to max with unf",
               int'($signed(acc)), 32767);

        // R6: clear drops both sticky flags
        cyc(0, 0, 1, 100, "R6"); cyc(0, 0, 0, 100, "R6");
        #2 chk(!ovf && !unf && acc == 16'd0, "R6", "flags after clear", int'(ovf) + int'(unf), 0);

        summary();
        $finish;
    end

endmodule